// File: doc/BRIEF.md
# Stack Frame Enter/Leave Sequencer

This block carries out the two frame operations of a 64-bit downward-growing stack: building a new procedure frame on entry and tearing it down on exit. A command carries the current stack pointer, the current frame pointer, a 16-bit local-area size and an 8-bit nesting depth. The block then runs the qword reads and writes the operation needs through one memory request/response port. When the sequence completes, it presents the new stack and frame pointers together with a one-cycle completion pulse.

On entry the caller's frame pointer is pushed. For nested frames, the chain of enclosing frame pointers is copied from the old frame into the new one, and the new frame pointer itself is pushed. The local area is then reserved. A locked read-then-write-back probe on the final stack pointer confirms that the location is writable and leaves its contents as they were. On exit the saved frame pointer is read back and the stack is popped past it. An error response on any access abandons the operation: the block returns to idle, raises a fault pulse and leaves the result pointers untouched.

The command port is valid/ready. `cmd_ready` is high only while the block is idle, and a command is taken on any clock edge where both `cmd_valid` and `cmd_ready` are high. The memory request port is valid/ready with back-pressure: once `mem_req_valid` is raised, the request fields stay fixed until `mem_req_ready` is seen. Responses cannot be back-pressured. Exactly one response is expected per accepted request, in a cycle after the one in which the request was accepted. Results and completion are pulses without back-pressure.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `mem_req_valid` are low, `cmd_ready` is high, and `res_sp` and `res_fp` are zero.
- R2: Only the low 5 bits of `cmd_level` select the nesting depth, so depths 0 to 31 are possible and bits 7:5 have no effect.
- R3: Entry (`cmd_exit`=0) first writes the incoming frame pointer to address `sp_in`-8. That address becomes the new frame pointer reported in `res_fp`.
- R4: For a depth L of 2 or more, L-1 qwords are copied. Copy k (k=1..L-1) reads address `fp_in`-8k and writes the value to `sp_in`-8-8k.
- R5: For a nonzero depth L, the new frame pointer is written after the copies at `sp_in`-8L-8. For depth 0 there are no copies and no such write.
- R6: On entry `res_sp` equals the stack pointer after all pushes minus the zero-extended size, using 64-bit wrap-around arithmetic. That is `sp_in`-8-size for depth 0 and `sp_in`-8L-8-size otherwise.
- R7: Entry ends with two accesses to address `res_sp` with `mem_req_lock` high: a read, then a write of the value just read. Memory is therefore unchanged at that address.
- R8: Exit (`cmd_exit`=1) reads address `fp_in`, sets `res_sp` to `fp_in`+8 and `res_fp` to the value read, and writes no memory.
- R9: `res_sp` and `res_fp` change only in the cycle in which `done` is high for one cycle, and `done` and `fault` are never high together.
- R10: An error response on any access returns the block to idle. It then pulses `fault` for one cycle, leaves `res_sp` and `res_fp` unchanged and issues no further request.
- R11: At most one memory request is outstanding. A request held without `mem_req_ready` keeps its address, direction and data, and the next request is issued only after the previous response.
- R12: `busy` is high from the cycle after a command is accepted until the cycle in which `done` or `fault` pulses, and `cmd_ready` is low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_exit | input | 1 | 0 = frame entry, 1 = frame exit |
| cmd_size | input | 16 | Local area size in bytes (entry) |
| cmd_level | input | 8 | Nesting depth (low 5 bits used) |
| sp_in | input | 64 | Current stack pointer |
| fp_in | input | 64 | Current frame pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle abort pulse after an error response |
| res_sp | output | 64 | Resulting stack pointer |
| res_fp | output | 64 | Resulting frame pointer |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_lock | output | 1 | Marks the two probe accesses |
| mem_req_addr | output | 64 | Byte address of the qword |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_err | input | 1 | Access failed |
| mem_rsp_data | input | 64 | Read data |

## Verification
The bench aims at the depth boundaries. Depth 1 must push the new frame pointer with no copy, so a loop counter that is off by one shows up as an extra or missing qword in the compared memory image. Depth 0 must skip both, and depths above 31 must fold back to their low 5 bits; an unmasked depth would copy far too many qwords. It also drives stack pointers near zero so that the pushes wrap, and uses the largest size, where a sign-extended or truncated size gives a wrong `res_sp`. Faults are injected on a copy write, on the probe write and on the exit read; a design that commits partial results or keeps issuing requests after the error is caught by the unchanged result pointers and an idle request line.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam int unsigned QWORD_BYTES = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_OLD,
    ST_COPY_RD,
    ST_COPY_WR,
    ST_PUSH_NEW,
    ST_PROBE_RD,
    ST_PROBE_WR,
    ST_EXIT_RD
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REQ,
    PH_RSP
  } port_phase_t;

endpackage

// File: rtl/sfs_memport.sv
module sfs_memport #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            go_we,
  input  logic            go_lock,
  input  logic [XLEN-1:0] go_addr,
  input  logic [XLEN-1:0] go_wdata,
  output logic            fin,
  output logic            fin_err,
  output logic [XLEN-1:0] fin_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic            mem_req_lock,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  input  logic [XLEN-1:0] mem_rsp_data
);
  import sfs_pkg::*;

  port_phase_t phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_lock  <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (go) begin
          phase         <= PH_REQ;
          mem_req_valid <= 1'b1;
          mem_req_we    <= go_we;
          mem_req_lock  <= go_lock;
          mem_req_addr  <= go_addr;
          mem_req_wdata <= go_wdata;
        end
        PH_REQ: if (mem_req_ready) begin
          phase         <= PH_RSP;
          mem_req_valid <= 1'b0;
        end
        PH_RSP: if (mem_rsp_valid) begin
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign fin      = (phase == PH_RSP) && mem_rsp_valid;
  assign fin_err  = mem_rsp_err;
  assign fin_data = mem_rsp_data;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  a_r11_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (phase == PH_IDLE));

  a_r11_no_req_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RSP) |-> !mem_req_valid);

endmodule

// File: rtl/sfs_ctl.sv
module sfs_ctl #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned DEPTH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_exit,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [LVL_W-1:0]  cmd_level,
  input  logic [XLEN-1:0]   sp_in,
  input  logic [XLEN-1:0]   fp_in,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [XLEN-1:0]   res_sp,
  output logic [XLEN-1:0]   res_fp,
  output logic              go,
  output logic              go_we,
  output logic              go_lock,
  output logic [XLEN-1:0]   go_addr,
  output logic [XLEN-1:0]   go_wdata,
  input  logic              fin,
  input  logic              fin_err,
  input  logic [XLEN-1:0]   fin_data
);
  import sfs_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(QWORD_BYTES);

  seq_state_t         state;
  logic [XLEN-1:0]    tsp, tfp, nfp, hold;
  logic [SIZE_W-1:0]  size_q;
  logic [DEPTH_W-1:0] cnt;
  logic               live;
  logic               access_state;
  logic [XLEN-1:0]    size_ext, probe_addr;

  assign size_ext   = {{(XLEN-SIZE_W){1'b0}}, size_q};
  assign probe_addr = tsp - size_ext;
  assign cmd_ready  = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign access_state = busy;
  assign go         = access_state && !live;

  always_comb begin
    go_we    = 1'b0;
    go_lock  = 1'b0;
    go_addr  = '0;
    go_wdata = '0;
    unique case (state)
      ST_PUSH_OLD: begin go_we = 1'b1; go_addr = tsp - STEP; go_wdata = tfp;  end
      ST_COPY_RD:  begin               go_addr = tfp - STEP;                  end
      ST_COPY_WR:  begin go_we = 1'b1; go_addr = tsp - STEP; go_wdata = hold; end
      ST_PUSH_NEW: begin go_we = 1'b1; go_addr = tsp - STEP; go_wdata = nfp;  end
      ST_PROBE_RD: begin go_lock = 1'b1; go_addr = probe_addr;                end
      ST_PROBE_WR: begin go_lock = 1'b1; go_we = 1'b1; go_addr = probe_addr; go_wdata = hold; end
      ST_EXIT_RD:  begin               go_addr = tfp;                         end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tsp    <= '0;
      tfp    <= '0;
      nfp    <= '0;
      hold   <= '0;
      size_q <= '0;
      cnt    <= '0;
      live   <= 1'b0;
      done   <= 1'b0;
      fault  <= 1'b0;
      res_sp <= '0;
      res_fp <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (go) live <= 1'b1;
      if (state == ST_IDLE) begin
        if (cmd_valid) begin
          tsp    <= sp_in;
          tfp    <= fp_in;
          size_q <= cmd_size;
          cnt    <= cmd_level[DEPTH_W-1:0];
          state  <= cmd_exit ? ST_EXIT_RD : ST_PUSH_OLD;
        end
      end else if (fin) begin
        live <= 1'b0;
        if (fin_err) begin
          state <= ST_IDLE;
          fault <= 1'b1;
        end else begin
          unique case (state)
            ST_PUSH_OLD: begin
              tsp <= tsp - STEP;
              nfp <= tsp - STEP;
              if (cnt == '0)      state <= ST_PROBE_RD;
              else if (cnt == 1)  state <= ST_PUSH_NEW;
              else begin
                cnt   <= cnt - 1'b1;
                state <= ST_COPY_RD;
              end
            end
            ST_COPY_RD: begin
              tfp   <= tfp - STEP;
              hold  <= fin_data;
              state <= ST_COPY_WR;
            end
            ST_COPY_WR: begin
              tsp <= tsp - STEP;
              if (cnt == 1) state <= ST_PUSH_NEW;
              else begin
                cnt   <= cnt - 1'b1;
                state <= ST_COPY_RD;
              end
            end
            ST_PUSH_NEW: begin
              tsp   <= tsp - STEP;
              state <= ST_PROBE_RD;
            end
            ST_PROBE_RD: begin
              hold  <= fin_data;
              state <= ST_PROBE_WR;
            end
            ST_PROBE_WR: begin
              res_sp <= probe_addr;
              res_fp <= nfp;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end
            ST_EXIT_RD: begin
              res_sp <= tfp + STEP;
              res_fp <= fin_data;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_sp) && $stable(res_fp)));

  a_r10_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!busy && !live));

  a_r4_copy_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_COPY_RD) || (state == ST_COPY_WR)) |-> (cnt != '0));

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned SIZE_W  = 16,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned DEPTH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_exit,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [LVL_W-1:0]  cmd_level,
  input  logic [XLEN-1:0]   sp_in,
  input  logic [XLEN-1:0]   fp_in,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [XLEN-1:0]   res_sp,
  output logic [XLEN-1:0]   res_fp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic              mem_req_lock,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [XLEN-1:0]   mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [XLEN-1:0]   mem_rsp_data
);

  logic            go, go_we, go_lock, fin, fin_err;
  logic [XLEN-1:0] go_addr, go_wdata, fin_data;

  sfs_ctl #(
    .XLEN(XLEN), .SIZE_W(SIZE_W), .LVL_W(LVL_W), .DEPTH_W(DEPTH_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_exit(cmd_exit),
    .cmd_size(cmd_size), .cmd_level(cmd_level),
    .sp_in(sp_in), .fp_in(fp_in),
    .busy(busy), .done(done), .fault(fault),
    .res_sp(res_sp), .res_fp(res_fp),
    .go(go), .go_we(go_we), .go_lock(go_lock),
    .go_addr(go_addr), .go_wdata(go_wdata),
    .fin(fin), .fin_err(fin_err), .fin_data(fin_data)
  );

  sfs_memport #(.XLEN(XLEN)) u_port (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_we(go_we), .go_lock(go_lock),
    .go_addr(go_addr), .go_wdata(go_wdata),
    .fin(fin), .fin_err(fin_err), .fin_data(fin_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_lock(mem_req_lock),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !fault && !mem_req_valid));

endmodule

// File: tb/sim_stack_frame_seq.sv
`timescale 1ns/1ps
module sim_stack_frame_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_exit = 1'b0;
  logic [15:0] cmd_size = '0;
  logic [7:0]  cmd_level = '0;
  logic [63:0] sp_in = '0, fp_in = '0;
  logic        busy, done, fault;
  logic [63:0] res_sp, res_fp;
  logic        mem_req_valid, mem_req_we, mem_req_lock;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  stack_frame_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_exit(cmd_exit),
    .cmd_size(cmd_size), .cmd_level(cmd_level),
    .sp_in(sp_in), .fp_in(fp_in),
    .busy(busy), .done(done), .fault(fault),
    .res_sp(res_sp), .res_fp(res_fp),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_lock(mem_req_lock),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int fails  = 0;

  logic [63:0] mem [0:1023];
  logic [63:0] em  [0:1023];
  logic        fault_armed = 1'b0;
  logic        fault_wr_only = 1'b0;
  logic [63:0] fault_addr = '0;
  logic [63:0] exp_sp, exp_fp;

  function automatic int unsigned ix(input logic [63:0] a);
    return int'(a[12:3]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model of entry, operating on the shadow image
  task automatic ref_enter(input logic [63:0] sp, input logic [63:0] fp,
                           input logic [15:0] size, input logic [7:0] lvl);
    int unsigned l = int'(lvl & 8'h1F);
    logic [63:0] t = sp - 64'd8;
    logic [63:0] tf = fp;
    logic [63:0] nf;
    em[ix(t)] = fp;
    nf = t;
    if (l > 0) begin
      for (int i = 1; i < int'(l); i++) begin
        tf = tf - 64'd8;
        t  = t - 64'd8;
        em[ix(t)] = em[ix(tf)];
      end
      t = t - 64'd8;
      em[ix(t)] = nf;
    end
    exp_sp = t - {48'd0, size};
    exp_fp = nf;
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (rst_n && mem_req_valid && ($urandom % 3 != 0)) begin
        logic [63:0] a, wd;
        logic we, lk, err;
        mem_req_ready = 1'b1;
        a = mem_req_addr; wd = mem_req_wdata; we = mem_req_we; lk = mem_req_lock;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        err = fault_armed && (a == fault_addr) && (!fault_wr_only || we);
        if (!err && we) begin
          if (lk) chk(wd == mem[ix(a)], "R7", wd, mem[ix(a)], "probe write-back data");
          mem[ix(a)] = wd;
        end
        mem_rsp_data  = mem[ix(a)];
        mem_rsp_err   = err;
        mem_rsp_valid = 1'b1;
      end
    end
  end

  task automatic run_op(input bit ex, input logic [15:0] size, input logic [7:0] lvl,
                        input logic [63:0] sp, input logic [63:0] fp,
                        input bit want_fault, input string req);
    logic [63:0] p_sp = res_sp, p_fp = res_fp;
    bit held = 1'b1;
    int n = 0;
    for (int i = 0; i < 1024; i++) em[i] = mem[i];
    if (!want_fault) begin
      if (ex) begin
        exp_sp = fp + 64'd8;
        exp_fp = em[ix(fp)];
      end else begin
        ref_enter(sp, fp, size, lvl);
      end
    end
    @(negedge clk);
    chk(cmd_ready, "R12", {63'd0, cmd_ready}, 64'd1, "ready when idle");
    cmd_valid = 1'b1; cmd_exit = ex; cmd_size = size; cmd_level = lvl;
    sp_in = sp; fp_in = fp;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R12", {63'd0, busy}, 64'd1, "busy after accept");
    while (!(done || fault) && n < 3000) begin
      if (res_sp != p_sp || res_fp != p_fp) held = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(held, "R9", res_sp, p_sp, "results held while busy");
    if (want_fault) begin
      chk(fault && !done, "R10", {63'd0, fault}, 64'd1, {req, " fault pulse"});
      chk(res_sp == p_sp && res_fp == p_fp, "R10", res_sp, p_sp, "results unchanged on fault");
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!mem_req_valid && !busy && !fault, "R10", {63'd0, mem_req_valid}, 64'd0, "quiet after fault");
      end
    end else begin
      chk(done && !fault, "R9", {63'd0, done}, 64'd1, {req, " done pulse"});
      chk(res_sp == exp_sp, req, res_sp, exp_sp, "res_sp");
      chk(res_fp == exp_fp, req, res_fp, exp_fp, "res_fp");
      begin
        bit same = 1'b1;
        int bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== em[i]) begin same = 1'b0; bad = i; end
        chk(same, req, mem[bad], em[bad], "memory image");
      end
      @(negedge clk);
      chk(!done, "R9", {63'd0, done}, 64'd0, "done lasts one cycle");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req_valid && cmd_ready, "R1",
        {60'd0, busy, done, fault, mem_req_valid}, 64'd0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_sp == 0 && res_fp == 0, "R1", res_sp, 64'd0, "reset results");

    // directed corners
    run_op(1'b0, 16'h0020, 8'd0,  64'h0000_7000_0000_1800, 64'h0000_7000_0000_1A00, 1'b0, "R5");
    run_op(1'b0, 16'h0010, 8'd1,  64'h0000_7000_0000_1800, 64'h0000_7000_0000_1A00, 1'b0, "R5");
    run_op(1'b0, 16'h0008, 8'd2,  64'h0000_7000_0000_1800, 64'h0000_7000_0000_1A00, 1'b0, "R4");
    run_op(1'b0, 16'h0000, 8'hE3, 64'h0000_7000_0000_1800, 64'h0000_7000_0000_1400, 1'b0, "R2");
    run_op(1'b0, 16'h0040, 8'd31, 64'h0000_7000_0000_1F00, 64'h0000_7000_0000_1600, 1'b0, "R4");
    run_op(1'b0, 16'h0040, 8'd32, 64'h0000_7000_0000_1F00, 64'h0000_7000_0000_1600, 1'b0, "R2");
    run_op(1'b0, 16'hFFFF, 8'd3,  64'h0000_0000_0000_0010, 64'h0000_0000_0000_0100, 1'b0, "R6");
    run_op(1'b0, 16'h0018, 8'd0,  64'h0000_7000_0000_0800, 64'h0000_7000_0000_0900, 1'b0, "R3");
    run_op(1'b1, 16'h0000, 8'd0,  64'h0,                   64'h0000_7000_0000_0FF8, 1'b0, "R8");

    // fault on a copy write
    fault_armed = 1'b1; fault_wr_only = 1'b1; fault_addr = 64'h0000_7000_0000_1800 - 64'd24;
    run_op(1'b0, 16'h0010, 8'd4, 64'h0000_7000_0000_1800, 64'h0000_7000_0000_1B00, 1'b1, "R10");
    // fault on the probe write (final sp = sp-8-size)
    fault_addr = 64'h0000_7000_0000_1800 - 64'd8 - 64'h30;
    run_op(1'b0, 16'h0030, 8'd0, 64'h0000_7000_0000_1800, 64'h0000_7000_0000_1B00, 1'b1, "R10");
    // fault on the exit read
    fault_wr_only = 1'b0; fault_addr = 64'h0000_7000_0000_1208;
    run_op(1'b1, 16'h0000, 8'd0, 64'h0, 64'h0000_7000_0000_1208, 1'b1, "R10");
    fault_armed = 1'b0;
    run_op(1'b1, 16'h0000, 8'd0, 64'h0, 64'h0000_7000_0000_1208, 1'b0, "R8");

    // random mix
    for (int r = 0; r < 40; r++) begin
      logic [63:0] sp = {$urandom, $urandom} & ~64'h7;
      logic [63:0] fp = {$urandom, $urandom} & ~64'h7;
      bit ex = ($urandom % 4 == 0);
      run_op(ex, 16'($urandom), 8'($urandom), sp, fp, 1'b0, ex ? "R8" : "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule